// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is a time-slot interchange for bit-serial TDM streams that share one bit clock and one frame pulse. Each frame holds a fixed number of 8-bit channels per stream. The block shifts every incoming channel byte into a data memory. For every output stream and channel, an entry in a host-written connection memory decides what goes out in that slot. The slot can carry a byte taken from any input stream and channel, a constant byte held in the entry itself, all ones, or nothing at all, with the driver disabled. A switched byte always leaves exactly two frames after it arrived, whatever its source and destination slots.

The host writes and reads entries through a plain one-cycle port. A new entry is held aside and becomes active only at the next frame boundary, so a slot never sends a mix of old and new settings. A small frame controller tracks alignment. It waits in SEARCH until the first frame pulse, moves to FILL0 on that pulse, moves to FILL1 at the next frame boundary, and moves to RUN at the boundary after that. RUN is kept at every later boundary. A frame boundary is either a frame pulse or the wrap of the bit position after the last bit of a frame. Reset returns the controller to SEARCH from any state.

Top module: `tsi_switch`

## Requirements
- R1: In connect mode (entry bits [EW-1:EW-2] = 0), the output slot carries the byte that arrived two frames earlier on the input stream named by entry bits [CW+SW-1:CW], in the channel named by entry bits [CW-1:0], most significant bit first, with ser_oe high.
- R2: In message mode (mode = 1), the slot carries entry bits [7:0], most significant bit first, with ser_oe high.
- R3: In drive-high mode (mode = 2), the slot outputs all ones with ser_oe high.
- R4: In tri-state mode (mode = 3), ser_oe is low for that slot, and ser_out is high whenever ser_oe is low.
- R5: The delay from input to output is two frames for every pairing of source and destination slot.
- R6: From reset until the third frame after the first frame pulse begins, every ser_oe is low and every ser_out is high.
- R7: A host write to an entry changes the output only from the next frame boundary on. A write made in the boundary cycle itself first affects the frame after that.
- R8: host_rdata shows the stored entry at host_addr one cycle later. In a cycle that also writes that address, it shows the value held before the write.
- R9: The bit for frame position P is sampled from ser_in on the clock edge of position P and appears on ser_out right after that same edge. Frame position 0 is the cycle with frame_pulse high, and each channel spans positions 8c to 8c+7.
- R10: Reset clears every connection entry to zero (connect from stream 0, channel 0), and host_rdata reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | High in the cycle of bit 0 of channel 0 |
| ser_in | input | NUM_STREAMS | Serial input streams |
| ser_out | output | NUM_STREAMS | Serial output data |
| ser_oe | output | NUM_STREAMS | Output driver enable for each stream |
| host_we | input | 1 | Host write strobe |
| host_addr | input | SW+CW | Entry index {stream, channel} |
| host_wdata | input | EW | Entry to write |
| host_rdata | output | EW | Entry read from host_addr, one cycle later |

## Verification
Two events can land in the same cycle: a host write and the frame boundary at which pending entries are copied to the active set. A read of an address can also land in the same cycle as a write to that address. The bench provokes both by rewriting the whole table starting at position 0 of a frame, by rewriting a single entry exactly in a boundary cycle, and by sweeping the read address through write cycles. It judges each output slot against a model in which the copy at a boundary uses the entries held before that cycle's write, and in which the read value is the one held before the write. It also rewrites an entry in the middle of a frame, before that entry's slot comes up, to confirm the change waits for the boundary.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    typedef enum logic [1:0] {
        MODE_CONNECT  = 2'd0,
        MODE_MESSAGE  = 2'd1,
        MODE_HIGH     = 2'd2,
        MODE_TRISTATE = 2'd3
    } slot_mode_e;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_FILL0  = 2'd1,
        ST_FILL1  = 2'd2,
        ST_RUN    = 2'd3
    } frame_state_e;

    localparam int BANKS = 3;

    function automatic logic [1:0] next_bank(input logic [1:0] b);
        return (b == 2'd2) ? 2'd0 : b + 2'd1;
    endfunction

endpackage

// File: rtl/tsi_frame_ctrl.sv
module tsi_frame_ctrl
    import tsi_pkg::*;
#(
    parameter int FRAME_BITS = 64,
    localparam int PW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_pulse,
    output logic [PW-1:0] cur_pos,
    output logic          boundary,
    output logic          in_frame,
    output logic          running,
    output logic [1:0]    wr_bank,
    output logic [1:0]    rd_bank
);

    localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BITS - 1);

    frame_state_e  state_q, state_d;
    logic [PW-1:0] pos_q;
    logic [1:0]    bank_q;
    logic          wrap;

    assign wrap = frame_pulse || (pos_q == LAST_POS);

    always_comb begin
        state_d  = state_q;
        boundary = 1'b0;
        unique case (state_q)
            ST_SEARCH: if (frame_pulse) begin
                state_d  = ST_FILL0;
                boundary = 1'b1;
            end
            ST_FILL0: if (wrap) begin
                state_d  = ST_FILL1;
                boundary = 1'b1;
            end
            ST_FILL1: if (wrap) begin
                state_d  = ST_RUN;
                boundary = 1'b1;
            end
            ST_RUN: if (wrap) begin
                boundary = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SEARCH;
        else        state_q <= state_d;
    end

    always_comb begin
        if (state_q == ST_SEARCH || boundary) cur_pos = '0;
        else                                  cur_pos = PW'(pos_q + 1'b1);
        if (state_q == ST_SEARCH) wr_bank = 2'd0;
        else if (boundary)        wr_bank = next_bank(bank_q);
        else                      wr_bank = bank_q;
        rd_bank  = next_bank(wr_bank);
        in_frame = (state_d != ST_SEARCH);
        running  = (state_d == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            bank_q <= 2'd0;
        end else begin
            pos_q  <= cur_pos;
            bank_q <= wr_bank;
        end
    end

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
    import tsi_pkg::*;
#(
    parameter int NUM_STREAMS  = 4,
    parameter int NUM_CHANNELS = 8,
    localparam int SW = $clog2(NUM_STREAMS),
    localparam int CW = $clog2(NUM_CHANNELS),
    localparam int PW = CW + 3
) (
    input  logic                            clk,
    input  logic                            in_frame,
    input  logic [PW-1:0]                   cur_pos,
    input  logic [1:0]                      wr_bank,
    input  logic [1:0]                      rd_bank,
    input  logic [NUM_STREAMS-1:0]          ser_in,
    input  logic [NUM_STREAMS-1:0][SW-1:0]  rd_stream,
    input  logic [NUM_STREAMS-1:0][CW-1:0]  rd_chan,
    output logic [NUM_STREAMS-1:0][7:0]     rd_byte
);

    logic [7:0] mem [BANKS][NUM_STREAMS][NUM_CHANNELS];
    logic [6:0] shreg [NUM_STREAMS];
    logic [CW-1:0] wr_chan;
    logic          byte_done;

    assign wr_chan   = cur_pos[PW-1:3];
    assign byte_done = in_frame && (cur_pos[2:0] == 3'd7);

    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_STREAMS; s++) begin
            shreg[s] <= {shreg[s][5:0], ser_in[s]};
            if (byte_done) mem[wr_bank][s][wr_chan] <= {shreg[s], ser_in[s]};
        end
    end

    always_comb begin
        for (int s = 0; s < NUM_STREAMS; s++) begin
            rd_byte[s] = mem[rd_bank][rd_stream[s]][rd_chan[s]];
        end
    end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
    parameter int NUM_STREAMS  = 4,
    parameter int NUM_CHANNELS = 8,
    parameter int EW           = 10,
    localparam int SW = $clog2(NUM_STREAMS),
    localparam int CW = $clog2(NUM_CHANNELS),
    localparam int AW = SW + CW,
    localparam int NE = NUM_STREAMS * NUM_CHANNELS
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            boundary,
    input  logic [CW-1:0]                   cur_chan,
    input  logic                            host_we,
    input  logic [AW-1:0]                   host_addr,
    input  logic [EW-1:0]                   host_wdata,
    output logic [EW-1:0]                   host_rdata,
    output logic [NUM_STREAMS-1:0][EW-1:0]  entry_out
);

    logic [EW-1:0] pending [NE];
    logic [EW-1:0] active  [NE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) begin
                pending[i] <= '0;
                active[i]  <= '0;
            end
            host_rdata <= '0;
        end else begin
            if (boundary) begin
                for (int i = 0; i < NE; i++) active[i] <= pending[i];
            end
            if (host_we) pending[host_addr] <= host_wdata;
            host_rdata <= pending[host_addr];
        end
    end

    always_comb begin
        for (int s = 0; s < NUM_STREAMS; s++) begin
            entry_out[s] = boundary ? pending[{SW'(s), cur_chan}]
                                    : active[{SW'(s), cur_chan}];
        end
    end

endmodule

// File: rtl/tsi_out_stage.sv
module tsi_out_stage
    import tsi_pkg::*;
#(
    parameter int NUM_STREAMS  = 4,
    parameter int NUM_CHANNELS = 8,
    parameter int EW           = 10,
    localparam int SW = $clog2(NUM_STREAMS),
    localparam int CW = $clog2(NUM_CHANNELS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            running,
    input  logic [2:0]                      bit_idx,
    input  logic [NUM_STREAMS-1:0][EW-1:0]  entry,
    input  logic [NUM_STREAMS-1:0][7:0]     rd_byte,
    output logic [NUM_STREAMS-1:0][SW-1:0]  src_stream,
    output logic [NUM_STREAMS-1:0][CW-1:0]  src_chan,
    output logic [NUM_STREAMS-1:0]          ser_out,
    output logic [NUM_STREAMS-1:0]          ser_oe
);

    slot_mode_e             mode [NUM_STREAMS];
    logic [NUM_STREAMS-1:0] out_d, oe_d;
    logic [2:0]             sel;

    assign sel = 3'd7 - bit_idx;

    always_comb begin
        for (int s = 0; s < NUM_STREAMS; s++) begin
            mode[s]       = slot_mode_e'(entry[s][EW-1 -: 2]);
            src_stream[s] = entry[s][CW +: SW];
            src_chan[s]   = entry[s][0 +: CW];
            out_d[s]      = 1'b1;
            oe_d[s]       = 1'b0;
            if (running) begin
                unique case (mode[s])
                    MODE_CONNECT: begin
                        out_d[s] = rd_byte[s][sel];
                        oe_d[s]  = 1'b1;
                    end
                    MODE_MESSAGE: begin
                        out_d[s] = entry[s][sel];
                        oe_d[s]  = 1'b1;
                    end
                    MODE_HIGH: begin
                        out_d[s] = 1'b1;
                        oe_d[s]  = 1'b1;
                    end
                    MODE_TRISTATE: begin
                        out_d[s] = 1'b1;
                        oe_d[s]  = 1'b0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out <= '1;
            ser_oe  <= '0;
        end else begin
            ser_out <= out_d;
            ser_oe  <= oe_d;
        end
    end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NUM_STREAMS  = 4,
    parameter int NUM_CHANNELS = 8,
    localparam int SW   = $clog2(NUM_STREAMS),
    localparam int CW   = $clog2(NUM_CHANNELS),
    localparam int AW   = SW + CW,
    localparam int PAYW = (AW > 8) ? AW : 8,
    localparam int EW   = PAYW + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_pulse,
    input  logic [NUM_STREAMS-1:0] ser_in,
    output logic [NUM_STREAMS-1:0] ser_out,
    output logic [NUM_STREAMS-1:0] ser_oe,
    input  logic                   host_we,
    input  logic [AW-1:0]          host_addr,
    input  logic [EW-1:0]          host_wdata,
    output logic [EW-1:0]          host_rdata
);

    localparam int FRAME_BITS = NUM_CHANNELS * 8;
    localparam int PW         = CW + 3;

    logic [PW-1:0]                  cur_pos;
    logic                           boundary, in_frame, running;
    logic [1:0]                     wr_bank, rd_bank;
    logic [NUM_STREAMS-1:0][EW-1:0] entry;
    logic [NUM_STREAMS-1:0][SW-1:0] src_stream;
    logic [NUM_STREAMS-1:0][CW-1:0] src_chan;
    logic [NUM_STREAMS-1:0][7:0]    rd_byte;

    tsi_frame_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .cur_pos     (cur_pos),
        .boundary    (boundary),
        .in_frame    (in_frame),
        .running     (running),
        .wr_bank     (wr_bank),
        .rd_bank     (rd_bank)
    );

    tsi_data_mem #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANNELS(NUM_CHANNELS)) u_dmem (
        .clk       (clk),
        .in_frame  (in_frame),
        .cur_pos   (cur_pos),
        .wr_bank   (wr_bank),
        .rd_bank   (rd_bank),
        .ser_in    (ser_in),
        .rd_stream (src_stream),
        .rd_chan   (src_chan),
        .rd_byte   (rd_byte)
    );

    tsi_conn_mem #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANNELS(NUM_CHANNELS), .EW(EW)) u_cmem (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (boundary),
        .cur_chan   (cur_pos[PW-1:3]),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .entry_out  (entry)
    );

    tsi_out_stage #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANNELS(NUM_CHANNELS), .EW(EW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .bit_idx    (cur_pos[2:0]),
        .entry      (entry),
        .rd_byte    (rd_byte),
        .src_stream (src_stream),
        .src_chan   (src_chan),
        .ser_out    (ser_out),
        .ser_oe     (ser_oe)
    );

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
    parameter int NUM_STREAMS  = 4,
    parameter int NUM_CHANNELS = 8,
    localparam int SW   = $clog2(NUM_STREAMS),
    localparam int CW   = $clog2(NUM_CHANNELS),
    localparam int AW   = SW + CW,
    localparam int PAYW = (AW > 8) ? AW : 8,
    localparam int EW   = PAYW + 2,
    localparam int PW   = CW + 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_pulse,
    input  logic [NUM_STREAMS-1:0] ser_out,
    input  logic [NUM_STREAMS-1:0] ser_oe,
    input  logic                   host_we,
    input  logic [AW-1:0]          host_addr,
    input  logic [EW-1:0]          host_wdata,
    input  logic [EW-1:0]          host_rdata
);

    localparam logic [PW-1:0] LAST_POS = PW'(NUM_CHANNELS * 8 - 1);

    logic          synced_q, early_q;
    logic [PW-1:0] cpos_q;
    logic [1:0]    fidx_q;
    logic [1:0]    fidx_n;

    assign fidx_n = (fidx_q == 2'd2) ? 2'd2 : fidx_q + 2'd1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced_q <= 1'b0;
            early_q  <= 1'b1;
            cpos_q   <= '0;
            fidx_q   <= 2'd0;
        end else if (!synced_q) begin
            early_q <= 1'b1;
            if (frame_pulse) begin
                synced_q <= 1'b1;
                cpos_q   <= '0;
                fidx_q   <= 2'd0;
            end
        end else if (frame_pulse || cpos_q == LAST_POS) begin
            cpos_q  <= '0;
            fidx_q  <= fidx_n;
            early_q <= (fidx_n != 2'd2);
        end else begin
            cpos_q  <= PW'(cpos_q + 1'b1);
            early_q <= (fidx_q != 2'd2);
        end
    end

    AST_TRISTATE_DATA_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ser_oe & ~ser_out) == '0)); // R4

    AST_IDLE_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        early_q |-> (ser_oe == '0)); // R6

    AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(host_we, 2) && !$past(host_we, 1) && ($past(host_addr, 2) == $past(host_addr, 1)))
        |-> (host_rdata == $past(host_wdata, 2))); // R8

    AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_we && !$past(host_we) && $stable(host_addr)) |=> $stable(host_rdata)); // R8

endmodule

bind tsi_switch tsi_switch_chk #(
    .NUM_STREAMS  (NUM_STREAMS),
    .NUM_CHANNELS (NUM_CHANNELS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (frame_pulse),
    .ser_out     (ser_out),
    .ser_oe      (ser_oe),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata)
);

// File: tb/tsi_switch_test.sv
module tsi_switch_test;

    localparam int NS   = 4;
    localparam int NC   = 8;
    localparam int SW   = $clog2(NS);
    localparam int CW   = $clog2(NC);
    localparam int AW   = SW + CW;
    localparam int EW   = ((AW > 8) ? AW : 8) + 2;
    localparam int NE   = NS * NC;
    localparam int FB   = NC * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_pulse = 1'b0;
    logic [NS-1:0] ser_in = '0;
    logic [NS-1:0] ser_out, ser_oe;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [EW-1:0] host_wdata = '0;
    logic [EW-1:0] host_rdata;

    always #2 clk = ~clk;

    tsi_switch #(.NUM_STREAMS(NS), .NUM_CHANNELS(NC)) uut (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ser_in(ser_in),
        .ser_out(ser_out), .ser_oe(ser_oe), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [EW-1:0] sh_m [NE];
    logic [EW-1:0] ac_m [NE];
    logic [NS-1:0] exp_out, exp_oe;
    string         exp_tag [NS];
    logic [EW-1:0] exp_rd;
    string         rd_tag;
    bit            have_exp = 1'b0;

    function automatic logic [7:0] inb(input int f, input int s, input int c);
        return 8'((f * 29 + s * 71 + c * 13 + 7) & 255);
    endfunction

    function automatic logic [EW-1:0] cfg(input int set, input int idx);
        logic [EW-1:0] e;
        int m, src;
        e   = '0;
        m   = (idx + set) % 8;
        src = (idx * 7 + set * 5 + 3) % NE;
        if (m == 3) begin
            e[EW-1 -: 2] = 2'd1;
            e[7:0] = 8'((idx * 37 + set * 11 + 90) & 255);
        end else if (m == 5) begin
            e[EW-1 -: 2] = 2'd2;
        end else if (m == 6) begin
            e[EW-1 -: 2] = 2'd3;
        end else begin
            e[CW +: SW] = SW'(src / NC);
            e[0 +: CW]  = CW'(src % NC);
        end
        return e;
    endfunction

    task automatic check_prev();
        if (have_exp) begin
            for (int s = 0; s < NS; s++) begin
                tests++;
                if (ser_out[s] !== exp_out[s] || ser_oe[s] !== exp_oe[s]) begin
                    fails++;
                    $display("FAIL %s stream %0d: actual out=%b oe=%b expected out=%b oe=%b",
                             exp_tag[s], s, ser_out[s], ser_oe[s], exp_out[s], exp_oe[s]);
                end
            end
            tests++;
            if (host_rdata !== exp_rd) begin
                fails++;
                $display("FAIL %s host read: actual=%h expected=%h", rd_tag, host_rdata, exp_rd);
            end
        end
    endtask

    task automatic step(input bit fp, input int f, input int p, input bit w,
                        input int addr, input logic [EW-1:0] wd, input string rdtag);
        int c, b, ss, sc;
        logic [7:0] bt;
        logic [EW-1:0] e;
        @(negedge clk);
        check_prev();
        if (f >= 0 && p == 0) for (int i = 0; i < NE; i++) ac_m[i] = sh_m[i];
        exp_rd = sh_m[addr];
        rd_tag = rdtag;
        if (w) sh_m[addr] = wd;
        frame_pulse = fp;
        host_we     = w;
        host_addr   = AW'(addr);
        host_wdata  = wd;
        c = p / 8;
        b = p % 8;
        for (int s = 0; s < NS; s++) begin
            bt = (f >= 0) ? inb(f, s, c) : 8'h00;
            ser_in[s] = bt[7 - b];
        end
        for (int s = 0; s < NS; s++) begin
            if (f < 2) begin
                exp_out[s] = 1'b1; exp_oe[s] = 1'b0; exp_tag[s] = "R6 idle";
            end else begin
                e = ac_m[s * NC + c];
                case (e[EW-1 -: 2])
                    2'd0: begin
                        ss = int'(e[CW +: SW]);
                        sc = int'(e[0 +: CW]);
                        bt = inb(f - 2, ss, sc);
                        exp_out[s] = bt[7 - b]; exp_oe[s] = 1'b1;
                        exp_tag[s] = "R1 R5 R9 R7 connect";
                    end
                    2'd1: begin
                        exp_out[s] = e[7 - b]; exp_oe[s] = 1'b1;
                        exp_tag[s] = "R2 R7 message";
                    end
                    2'd2: begin
                        exp_out[s] = 1'b1; exp_oe[s] = 1'b1;
                        exp_tag[s] = "R3 R7 drive-high";
                    end
                    default: begin
                        exp_out[s] = 1'b1; exp_oe[s] = 1'b0;
                        exp_tag[s] = "R4 R7 tri-state";
                    end
                endcase
            end
        end
        have_exp = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        check_prev();
        have_exp    = 1'b0;
        rst_n       = 1'b0;
        host_we     = 1'b0;
        frame_pulse = 1'b0;
        repeat (3) @(negedge clk);
        tests++;
        if (ser_oe !== '0 || ser_out !== '1 || host_rdata !== '0) begin
            fails++;
            $display("FAIL R10 reset state: actual out=%b oe=%b rd=%h expected out=%b oe=0 rd=0",
                     ser_out, ser_oe, host_rdata, {NS{1'b1}});
        end
        rst_n = 1'b1;
        for (int i = 0; i < NE; i++) begin
            sh_m[i] = '0;
            ac_m[i] = '0;
        end
    endtask

    initial begin
        logic [EW-1:0] wd;
        bit w;
        int addr;
        do_reset();
        // idle cycles before the first frame pulse
        for (int i = 0; i < 4; i++) step(1'b0, -1, 0, 1'b0, i, '0, "R10");
        // phase A: full table loads, boundary-cycle write, mid-frame writes
        for (int f = 0; f < 8; f++) begin
            for (int p = 0; p < FB; p++) begin
                w = 1'b0; addr = (p * 3 + f) % NE; wd = '0;
                if (f == 0 && p < NE) begin w = 1'b1; addr = p; wd = cfg(0, p); end
                if (f == 3 && p < NE) begin w = 1'b1; addr = p; wd = cfg(1, p); end
                if (f == 5 && p == 0) begin
                    w = 1'b1; addr = 0; wd = '0; wd[EW-1 -: 2] = 2'd1; wd[7:0] = 8'hC3;
                end
                if (f == 6 && p == 10) begin
                    w = 1'b1; addr = NE - 1; wd = '0; wd[EW-1 -: 2] = 2'd2;
                end
                if (f == 6 && p == 40) begin
                    w = 1'b1; addr = 1; wd = '0; wd[EW-1 -: 2] = 2'd3;
                end
                step(p == 0, f, p, w, addr, wd, "R8");
            end
        end
        // phase B: reset clears table, single frame pulse then free-running wrap
        do_reset();
        for (int f = 0; f < 4; f++) begin
            for (int p = 0; p < FB; p++) begin
                step(f == 0 && p == 0, f, p, 1'b0, p % NE, '0, "R10");
            end
        end
        @(negedge clk);
        check_prev();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL R6 watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule